// File: doc/BRIEF.md
# Fetch-Path Instruction Hardening Rewriter

This block sits on the instruction-fetch path between program memory and a processor core. Every fetched word passes through it. Words whose opcode is not in a design-time hardening set go through unchanged. When a fetched word carries a hardened opcode, the block returns a generated five-word sequence in its place. The sequence stores the first source register to a reserved checker address, then stores the second source register there. It then executes the original operation, stores the destination register to the checker address, and branches to the instruction that follows the original one. The program image in memory is never modified.

During the four fetches that follow a trigger, the block drives the sequence words and holds the memory read strobe low. On the data side, the block watches writes to the reserved checker address and captures their values in order. The first value is the first operand, the second is the second operand, and the third is the result. A checker that recomputes the operation can use these values and the opcode captured at the trigger.

The instruction format is 32 bits wide: opcode [31:28], destination [27:24], first source [23:20], second source [19:16] and a 16-bit immediate [15:0]. The instruction size is 4 bytes.

Top module: `fetch_harden_rewriter`

## Requirements
- R1: When no sequence is active and the fetched opcode has its HARDEN_MASK bit clear, `cpu_rdata` equals `mem_rdata` and `mem_rd` follows `cpu_rd`.
- R2: A fetch of a word whose opcode has its HARDEN_MASK bit set, while no sequence is active, returns the store word {OP_ST, 4'h0, src1, 4'h0, CHK_ADDR} and starts a sequence.
- R3: The next four fetch strobes return, in this order: {OP_ST, 4'h0, src2, 4'h0, CHK_ADDR}, the original word unchanged, {OP_ST, 4'h0, dst, 4'h0, CHK_ADDR}, and the branch {OP_BR, 12'h0, trigger address + 4}.
- R4: After the branch word is fetched, pass-through resumes. A hardened opcode returned in the original-operation slot does not start a new sequence.
- R5: While a sequence is active, `mem_rd` is low, and the `mem_rdata` value does not affect `cpu_rdata`.
- R6: The hardening set is the parameter HARDEN_MASK, with bit n selecting opcode n.
- R7: After a trigger, the first three data writes to CHK_ADDR raise `cap_src1_vld`, then `cap_src2_vld`, then `cap_dst_vld`. Each strobe lasts one cycle and appears in the cycle after its write. In that cycle `cap_data` holds the written value. `cap_opcode` holds the opcode of the word that caused the trigger, from the cycle after the trigger.
- R8: Writes to other addresses, and writes to CHK_ADDR beyond the third since the last trigger or before any trigger, raise no strobe and leave `cap_data` unchanged.
- R9: Reset leaves no sequence active, all strobes low, `cap_data` zero and `cap_opcode` zero.
- R10: A hardened word fetched immediately after a branch slot starts a new sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_rd | input | 1 | Processor instruction fetch strobe |
| cpu_addr | input | AW | Processor fetch address |
| mem_rdata | input | 32 | Word read from program memory |
| mem_rd | output | 1 | Read strobe forwarded to program memory |
| cpu_rdata | output | 32 | Word returned to the processor |
| dbus_we | input | 1 | Processor data write strobe |
| dbus_addr | input | AW | Processor data write address |
| dbus_wdata | input | 32 | Processor data write value |
| cap_src1_vld | output | 1 | First operand captured (one cycle) |
| cap_src2_vld | output | 1 | Second operand captured (one cycle) |
| cap_dst_vld | output | 1 | Result captured (one cycle) |
| cap_data | output | 32 | Last captured value |
| cap_opcode | output | 4 | Opcode of the hardened instruction |

## Verification
The bench builds the block with HARDEN_MASK = 16'h002E (opcodes 1, 2, 3 and 5) and CHK_ADDR = 16'h0F00. Opcode 5 is hardened only in this configuration, so it shows that the mask parameter alone decides the set. Opcodes 0, 4, 6, 7 and 10 stay plain. The bench program places hardened words right after other hardened words, so that sequence fetches read hardened memory words that must be ignored and so that back-to-back triggers happen after a branch. Stray writes to a neighbouring address and to CHK_ADDR outside the capture window test that such writes are ignored.

// File: rtl/fhr_pkg.sv
package fhr_pkg;

    typedef enum logic [2:0] {
        SLOT_SRC1   = 3'd0,
        SLOT_SRC2   = 3'd1,
        SLOT_EXEC   = 3'd2,
        SLOT_DST    = 3'd3,
        SLOT_BRANCH = 3'd4
    } slot_e;

    typedef struct packed {
        logic [3:0]  op;
        logic [3:0]  dst;
        logic [3:0]  src1;
        logic [3:0]  src2;
        logic [15:0] imm;
    } insn_t;

    function automatic logic [31:0] mk_store(input logic [3:0] op_st,
                                             input logic [3:0] rsel,
                                             input logic [15:0] addr);
        return {op_st, 4'h0, rsel, 4'h0, addr};
    endfunction

    function automatic logic [31:0] mk_branch(input logic [3:0] op_br,
                                              input logic [15:0] tgt);
        return {op_br, 12'h000, tgt};
    endfunction

endpackage

// File: rtl/fhr_opsel.sv
module fhr_opsel #(
    parameter int          OPW  = 4,
    parameter logic [15:0] MASK = 16'h000E
) (
    input  logic [OPW-1:0] op,
    output logic           hit
);
    localparam int NOPS = 1 << OPW;

    logic [NOPS-1:0] match;

    for (genvar g = 0; g < NOPS; g++) begin : g_op
        assign match[g] = MASK[g] && (op == OPW'(g));
    end

    assign hit = |match;
endmodule

// File: rtl/fhr_seqgen.sv
module fhr_seqgen
    import fhr_pkg::*;
#(
    parameter int          AW       = 16,
    parameter int          ISZ      = 4,
    parameter logic [3:0]  OP_ST    = 4'hD,
    parameter logic [3:0]  OP_BR    = 4'hF,
    parameter logic [15:0] CHK_ADDR = 16'hFFF0
) (
    input  slot_e          slot,
    input  insn_t          insn,
    input  logic [AW-1:0]  base,
    output logic [31:0]    word
);
    logic [AW-1:0] next_pc;

    assign next_pc = base + AW'(ISZ);

    always_comb begin
        unique case (slot)
            SLOT_SRC1:   word = mk_store(OP_ST, insn.src1, CHK_ADDR);
            SLOT_SRC2:   word = mk_store(OP_ST, insn.src2, CHK_ADDR);
            SLOT_EXEC:   word = insn;
            SLOT_DST:    word = mk_store(OP_ST, insn.dst, CHK_ADDR);
            SLOT_BRANCH: word = mk_branch(OP_BR, 16'(next_pc));
            default:     word = insn;
        endcase
    end
endmodule

// File: rtl/fhr_capture.sv
module fhr_capture #(
    parameter int          AW       = 16,
    parameter int          DW       = 32,
    parameter int          OPW      = 4,
    parameter logic [15:0] CHK_ADDR = 16'hFFF0
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           arm,
    input  logic [OPW-1:0] arm_op,
    input  logic           wr_en,
    input  logic [AW-1:0]  wr_addr,
    input  logic [DW-1:0]  wr_data,
    output logic           src1_vld,
    output logic           src2_vld,
    output logic           dst_vld,
    output logic [DW-1:0]  data,
    output logic [OPW-1:0] opcode
);
    localparam logic [1:0] CNT_DONE = 2'd3;

    typedef struct packed {
        logic [1:0]     cnt;
        logic           s1;
        logic           s2;
        logic           sd;
        logic [DW-1:0]  data;
        logic [OPW-1:0] op;
    } cap_t;

    cap_t cap_d, cap_q;
    logic hit_chk;

    assign hit_chk = wr_en && (wr_addr == AW'(CHK_ADDR));

    always_comb begin
        cap_d    = cap_q;
        cap_d.s1 = 1'b0;
        cap_d.s2 = 1'b0;
        cap_d.sd = 1'b0;
        if (arm) begin
            cap_d.cnt = 2'd0;
            cap_d.op  = arm_op;
        end else if (hit_chk && cap_q.cnt != CNT_DONE) begin
            cap_d.s1   = (cap_q.cnt == 2'd0);
            cap_d.s2   = (cap_q.cnt == 2'd1);
            cap_d.sd   = (cap_q.cnt == 2'd2);
            cap_d.data = wr_data;
            cap_d.cnt  = cap_q.cnt + 2'd1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_q     <= '0;
            cap_q.cnt <= CNT_DONE;
        end else begin
            cap_q <= cap_d;
        end
    end

    assign src1_vld = cap_q.s1;
    assign src2_vld = cap_q.s2;
    assign dst_vld  = cap_q.sd;
    assign data     = cap_q.data;
    assign opcode   = cap_q.op;
endmodule

// File: rtl/fetch_harden_rewriter.sv
module fetch_harden_rewriter
    import fhr_pkg::*;
#(
    parameter int          AW          = 16,
    parameter int          ISZ         = 4,
    parameter logic [15:0] HARDEN_MASK = 16'h000E,
    parameter logic [3:0]  OP_ST       = 4'hD,
    parameter logic [3:0]  OP_BR       = 4'hF,
    parameter logic [15:0] CHK_ADDR    = 16'hFFF0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cpu_rd,
    input  logic [AW-1:0] cpu_addr,
    input  logic [31:0]   mem_rdata,
    output logic          mem_rd,
    output logic [31:0]   cpu_rdata,
    input  logic          dbus_we,
    input  logic [AW-1:0] dbus_addr,
    input  logic [31:0]   dbus_wdata,
    output logic          cap_src1_vld,
    output logic          cap_src2_vld,
    output logic          cap_dst_vld,
    output logic [31:0]   cap_data,
    output logic [3:0]    cap_opcode
);
    typedef struct packed {
        logic          active;
        slot_e         slot;
        insn_t         insn;
        logic [AW-1:0] base;
    } seq_t;

    seq_t          seq_d, seq_q;
    insn_t         mem_insn;
    logic          hit;
    logic          trig;
    logic          seq_active;
    slot_e         gen_slot;
    insn_t         gen_insn;
    logic [31:0]   gen_word;

    assign mem_insn   = mem_rdata;
    assign seq_active = seq_q.active;

    fhr_opsel #(.OPW(4), .MASK(HARDEN_MASK)) u_opsel (
        .op  (mem_insn.op),
        .hit (hit)
    );

    assign trig     = cpu_rd && !seq_q.active && hit;
    assign gen_slot = seq_q.active ? seq_q.slot : SLOT_SRC1;
    assign gen_insn = seq_q.active ? seq_q.insn : mem_insn;

    fhr_seqgen #(
        .AW(AW), .ISZ(ISZ), .OP_ST(OP_ST), .OP_BR(OP_BR), .CHK_ADDR(CHK_ADDR)
    ) u_seqgen (
        .slot (gen_slot),
        .insn (gen_insn),
        .base (seq_q.base),
        .word (gen_word)
    );

    always_comb begin
        seq_d = seq_q;
        if (trig) begin
            seq_d.active = 1'b1;
            seq_d.slot   = SLOT_SRC2;
            seq_d.insn   = mem_insn;
            seq_d.base   = cpu_addr;
        end else if (cpu_rd && seq_q.active) begin
            if (seq_q.slot == SLOT_BRANCH) begin
                seq_d.active = 1'b0;
                seq_d.slot   = SLOT_SRC1;
            end else begin
                seq_d.slot = slot_e'(seq_q.slot + 3'd1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q      <= '0;
            seq_q.slot <= SLOT_SRC1;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign mem_rd    = cpu_rd && !seq_q.active;
    assign cpu_rdata = (seq_q.active || hit) ? gen_word : mem_rdata;

    fhr_capture #(.AW(AW), .DW(32), .OPW(4), .CHK_ADDR(CHK_ADDR)) u_capture (
        .clk      (clk),
        .rst_n    (rst_n),
        .arm      (trig),
        .arm_op   (mem_insn.op),
        .wr_en    (dbus_we),
        .wr_addr  (dbus_addr),
        .wr_data  (dbus_wdata),
        .src1_vld (cap_src1_vld),
        .src2_vld (cap_src2_vld),
        .dst_vld  (cap_dst_vld),
        .data     (cap_data),
        .opcode   (cap_opcode)
    );
endmodule

// File: rtl/fhr_checker.sv
module fhr_checker #(
    parameter logic [15:0] HARDEN_MASK = 16'h000E,
    parameter logic [3:0]  OP_ST       = 4'hD
) (
    input logic        clk,
    input logic        rst_n,
    input logic        cpu_rd,
    input logic        mem_rd,
    input logic [31:0] mem_rdata,
    input logic [31:0] cpu_rdata,
    input logic        seq_active,
    input logic        cap_src1_vld,
    input logic        cap_src2_vld,
    input logic        cap_dst_vld
);
    p_passthru_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_rd && !seq_active && !HARDEN_MASK[mem_rdata[31:28]])
        |-> (cpu_rdata == mem_rdata && mem_rd));

    p_first_store_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_rd && !seq_active && HARDEN_MASK[mem_rdata[31:28]])
        |-> (cpu_rdata[31:28] == OP_ST && cpu_rdata[23:20] == mem_rdata[23:20]));

    p_trigger_starts_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_rd && !seq_active && HARDEN_MASK[mem_rdata[31:28]]) |=> seq_active);

    p_fetch_blocked_r5: assert property (@(posedge clk) disable iff (!rst_n)
        seq_active |-> !mem_rd);

    p_cap_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cap_src1_vld, cap_src2_vld, cap_dst_vld}));

    p_src1_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cap_src1_vld |=> !cap_src1_vld);

    p_dst_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cap_dst_vld |=> !cap_dst_vld);
endmodule

bind fetch_harden_rewriter fhr_checker #(
    .HARDEN_MASK(HARDEN_MASK), .OP_ST(OP_ST)
) u_fhr_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .cpu_rd       (cpu_rd),
    .mem_rd       (mem_rd),
    .mem_rdata    (mem_rdata),
    .cpu_rdata    (cpu_rdata),
    .seq_active   (seq_active),
    .cap_src1_vld (cap_src1_vld),
    .cap_src2_vld (cap_src2_vld),
    .cap_dst_vld  (cap_dst_vld)
);

// File: tb/fetch_harden_rewriter_bench.sv
`timescale 1ns/1ps
module fetch_harden_rewriter_bench;
    localparam logic [15:0] MASK  = 16'h002E;
    localparam logic [15:0] CHK   = 16'h0F00;
    localparam logic [15:0] OTHER = 16'h0F04;
    localparam logic [3:0]  OPST  = 4'hD;
    localparam logic [3:0]  OPBR  = 4'hF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_rd = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic [31:0] mem_rdata = '0;
    logic        dbus_we = 1'b0;
    logic [15:0] dbus_addr = '0;
    logic [31:0] dbus_wdata = '0;
    logic        mem_rd, cap_src1_vld, cap_src2_vld, cap_dst_vld;
    logic [31:0] cpu_rdata, cap_data;
    logic [3:0]  cap_opcode;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    always #2 clk = ~clk;

    fetch_harden_rewriter #(
        .AW(16), .ISZ(4), .HARDEN_MASK(MASK), .OP_ST(OPST), .OP_BR(OPBR), .CHK_ADDR(CHK)
    ) u_fetch_harden_rewriter (
        .clk(clk), .rst_n(rst_n), .cpu_rd(cpu_rd), .cpu_addr(cpu_addr),
        .mem_rdata(mem_rdata), .mem_rd(mem_rd), .cpu_rdata(cpu_rdata),
        .dbus_we(dbus_we), .dbus_addr(dbus_addr), .dbus_wdata(dbus_wdata),
        .cap_src1_vld(cap_src1_vld), .cap_src2_vld(cap_src2_vld),
        .cap_dst_vld(cap_dst_vld), .cap_data(cap_data), .cap_opcode(cap_opcode)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] prog(input logic [15:0] a);
        logic [3:0] i;
        logic [3:0] ops [16];
        i = a[5:2];
        ops = '{4'h0, 4'h1, 4'h2, 4'h4, 4'h5, 4'h6, 4'h3, OPST,
                4'h1, 4'h0, 4'h2, 4'h7, 4'h3, 4'hA, 4'h5, 4'h0};
        if (ops[i] == OPST) return {OPST, 4'h0, 4'h3, 4'h0, OTHER};
        return {ops[i], i ^ 4'h4, i + 4'h1, ~i, 8'h00, 4'h0, i};
    endfunction

    function automatic logic [31:0] regval(input logic [3:0] r);
        return {4'hA, r, 8'h5A, 12'h123, r ^ 4'hF};
    endfunction

    function automatic bit is_hard(input logic [31:0] w);
        return MASK[w[31:28]];
    endfunction

    // behavioural reference state
    int          m_seq = 0;          // 0 idle, 1..4 index of next sequence word
    logic [31:0] m_held = '0;
    logic [15:0] m_base = '0;
    int          m_wcnt = 3;
    logic [2:0]  m_stb = '0;         // {dst, src2, src1}
    logic [31:0] m_data = '0;
    logic [3:0]  m_op = '0;
    bit          m_after_br = 0;

    function automatic logic [31:0] st_word(input logic [3:0] r);
        return {OPST, 4'h0, r, 4'h0, CHK};
    endfunction

    function automatic logic [31:0] exp_word(input logic [31:0] mem);
        case (m_seq)
            0: return is_hard(mem) ? st_word(mem[23:20]) : mem;
            1: return st_word(m_held[19:16]);
            2: return m_held;
            3: return st_word(m_held[27:24]);
            default: return {OPBR, 12'h000, m_base + 16'd4};
        endcase
    endfunction

    initial begin
        #400000;
        if (!done) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [15:0] pc;
        bit          pend;
        logic [15:0] pend_addr;
        logic [31:0] pend_data;
        logic [31:0] ew;
        string       tag;
        bit          counted;
        pc = 16'h0000;
        pend = 0;
        pend_addr = '0;
        pend_data = '0;

        // R9: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        mem_rdata = prog(16'h0004);
        cpu_addr  = 16'h0004;
        #1;
        chk("R9 strobes", {29'd0, cap_dst_vld, cap_src2_vld, cap_src1_vld}, 32'd0);
        chk("R9 cap_data", cap_data, 32'd0);
        chk("R9 cap_opcode", {28'd0, cap_opcode}, 32'd0);
        chk("R9 mem_rd", {31'd0, mem_rd}, 32'd0);
        rst_n = 1'b1;

        for (int cyc = 0; cyc < 600; cyc++) begin
            @(negedge clk);
            cpu_rd    = (cyc % 7 != 3);
            cpu_addr  = pc;
            mem_rdata = prog(pc);
            if (pend) begin
                dbus_we = 1'b1; dbus_addr = pend_addr; dbus_wdata = pend_data;
            end else if (cyc % 11 == 5) begin
                dbus_we = 1'b1; dbus_addr = OTHER; dbus_wdata = 32'hDEAD_0000 | cyc;
            end else if (cyc % 23 == 9) begin
                dbus_we = 1'b1; dbus_addr = CHK; dbus_wdata = 32'hBEEF_0000 | cyc;
            end else begin
                dbus_we = 1'b0; dbus_addr = '0; dbus_wdata = '0;
            end
            pend = 0;
            #1;
            ew = exp_word(mem_rdata);
            if (m_seq == 0) begin
                if (!is_hard(mem_rdata)) tag = m_after_br ? "R4" : "R1";
                else if (m_after_br) tag = "R10";
                else if (mem_rdata[31:28] == 4'h5) tag = "R6";
                else tag = "R2";
            end else tag = "R3";
            if (cpu_rd) chk({tag, " cpu_rdata"}, cpu_rdata, ew);
            chk(m_seq != 0 ? "R5 mem_rd" : "R1 mem_rd", {31'd0, mem_rd},
                {31'd0, cpu_rd && m_seq == 0});
            chk("R7 strobes", {29'd0, cap_dst_vld, cap_src2_vld, cap_src1_vld}, {29'd0, m_stb});
            chk("R8 cap_data", cap_data, m_data);
            chk("R7 cap_opcode", {28'd0, cap_opcode}, {28'd0, m_op});

            @(posedge clk);
            // reference update for the edge just taken
            m_stb = '0;
            counted = 0;
            if (cpu_rd && m_seq == 0 && is_hard(mem_rdata)) begin
                m_seq = 1; m_held = mem_rdata; m_base = cpu_addr;
                m_wcnt = 0; m_op = mem_rdata[31:28];
            end else begin
                if (dbus_we && dbus_addr == CHK && m_wcnt < 3) begin
                    m_stb[m_wcnt] = 1'b1;
                    m_data = dbus_wdata;
                    m_wcnt++;
                    counted = 1;
                end
                if (cpu_rd && m_seq != 0) m_seq = (m_seq == 4) ? 0 : m_seq + 1;
            end
            if (cpu_rd) begin
                m_after_br = (ew[31:28] == OPBR) && (m_seq == 0);
                if (ew[31:28] == OPBR) pc = ew[15:0];
                else pc = pc + 16'd4;
                if (ew[31:28] == OPST) begin
                    pend = 1; pend_addr = ew[15:0]; pend_data = regval(ew[23:20]);
                end
            end
        end

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule